// File: doc/BRIEF.md
# Single-Item Vending Controller

A synchronous controller for a machine that sells one item at a fixed price of 75 cents. Coins arrive as single-cycle strobes carrying a coin value; the controller adds each accepted coin to a running total and, one cycle later, compares that total with the price. An exact total releases the item. An excess total makes change and then releases the item when change is on hand, and refunds every coin when it is not. A return request while waiting refunds every coin.

The state is held in six one-hot flops, and the three results of the price comparison are formed combinationally from the total. Every output is a Moore pulse lasting exactly one cycle. Coins and return requests are taken only while the machine is waiting; in every other state they are ignored.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the controller waits with a total of zero and all three outputs low.
- R2: While waiting, a high `coin_stb` adds `coin_val` to the total and moves to the evaluate state. If `ret_req` is high in the same cycle, it has no effect.
- R3: While waiting, `ret_req` high with `coin_stb` low gives one cycle of `refund_all` after the next edge, and the controller then waits again.
- R4: In the evaluate state, a total below 75 returns the controller to waiting with no output, and the total is kept for further coins.
- R5: In the evaluate state, a total of exactly 75 gives one cycle of `release_item`. That pulse is seen two edges after the coin that completed the total.
- R6: In the evaluate state, a total above 75 with `chg_avail` high one edge later gives one cycle of `give_change`, then one cycle of `release_item`, then a return to waiting.
- R7: In the same case with `chg_avail` low, the controller gives one cycle of `refund_all` and does not release the item.
- R8: The total clears to zero when the controller leaves the release state or the refund state.
- R9: Outside the waiting state, `coin_stb`, `coin_val` and `ret_req` have no effect on the total or on the sequence.
- R10: Exactly one state flop is set at all times. The state codes are waiting=000001, evaluate=000010, release=000100, change-check=001000, give-change=010000 and refund=100000. At most one output is high.
- R11: The total never wraps. With the default 7-bit coin width, a total of 74 followed by a coin of 127 gives 201, which takes the change path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_stb | input | 1 | One-cycle coin-inserted strobe |
| coin_val | input | COIN_W | Value of the inserted coin in cents |
| ret_req | input | 1 | Request to refund all coins |
| chg_avail | input | 1 | Change is on hand |
| release_item | output | 1 | Release-item pulse |
| give_change | output | 1 | Return-change pulse |
| refund_all | output | 1 | Return-all-coins pulse |

## Verification
The embedded properties check on every cycle that the state stays one-hot and the outputs stay mutually exclusive. They also check that a change pulse is always followed by a release pulse, that a refund request while waiting produces a refund, that an exact total produces a release, and that the total holds steady outside the states that change it. Only the bench's scenarios can show the actual totals. These cover accumulation over several coins, clearing after release and after refund, the boundary totals 74 and 75, the largest coin on top of 74 without wrap, and the priority of a coin over a return request.

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int PRICE  = 75,
  parameter int COIN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coin_stb,
  input  logic [COIN_W-1:0] coin_val,
  input  logic              ret_req,
  input  logic              chg_avail,
  output logic              release_item,
  output logic              give_change,
  output logic              refund_all
);
  localparam int SUM_MAX = (PRICE - 1) + (1 << COIN_W) - 1;
  localparam int SUM_W   = $clog2(SUM_MAX + 1);
  localparam int S_IDLE = 0, S_EVAL = 1, S_REL = 2, S_CHK = 3, S_RCHG = 4, S_REF = 5;
  localparam logic [SUM_W-1:0] PRICE_V = SUM_W'(PRICE);

  logic [5:0]       state, state_nx;
  logic [SUM_W-1:0] sum;
  logic             lt, eq, gt, take_coin, clear;

  assign lt = sum <  PRICE_V;
  assign eq = sum == PRICE_V;
  assign gt = sum >  PRICE_V;
  assign take_coin = state[S_IDLE] & coin_stb;
  assign clear     = state[S_REL] | state[S_REF];

  always_comb begin
    state_nx = '0;
    unique case (1'b1)
      state[S_IDLE]: if (coin_stb)     state_nx[S_EVAL] = 1'b1;
                     else if (ret_req) state_nx[S_REF]  = 1'b1;
                     else              state_nx[S_IDLE] = 1'b1;
      state[S_EVAL]: if (eq)      state_nx[S_REL]  = 1'b1;
                     else if (gt) state_nx[S_CHK]  = 1'b1;
                     else         state_nx[S_IDLE] = 1'b1;
      state[S_CHK]:  if (chg_avail) state_nx[S_RCHG] = 1'b1;
                     else           state_nx[S_REF]  = 1'b1;
      state[S_RCHG]: state_nx[S_REL]  = 1'b1;
      default:       state_nx[S_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 6'b000001;
      sum   <= '0;
    end else begin
      state <= state_nx;
      if (clear)          sum <= '0;
      else if (take_coin) sum <= sum + SUM_W'(coin_val);
    end
  end

  assign release_item = state[S_REL];
  assign give_change  = state[S_RCHG];
  assign refund_all   = state[S_REF];

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);
  p_out_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({release_item, give_change, refund_all}));
  p_change_then_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    give_change |=> release_item);
  p_ret_refund_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state[S_IDLE] && ret_req && !coin_stb) |=> refund_all);
  p_exact_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state[S_EVAL] && sum == PRICE_V) |=> release_item);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_item || refund_all) |=> (sum == '0 && state[S_IDLE]));
  p_hold_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!state[S_IDLE] && !clear) |=> $stable(sum));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_coin |=> sum >= $past(sum));
endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic coin_stb = 1'b0, ret_req = 1'b0, chg_avail = 1'b0;
  logic [6:0] coin_val = '0;
  logic release_item, give_change, refund_all;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vend_ctrl dut_i (.clk(clk), .rst_n(rst_n), .coin_stb(coin_stb), .coin_val(coin_val),
    .ret_req(ret_req), .chg_avail(chg_avail), .release_item(release_item),
    .give_change(give_change), .refund_all(refund_all));

  // row: req[4] stb[1] val[7] ret[1] chg[1] exp{rel,chg,ref}[3]
  localparam int NV = 33;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b1, 7'd25, 1'b0, 1'b0, 3'b000},  // R2 coin 25
    {4'd4, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},  // R4 below price, back to wait
    {4'd2, 1'b1, 7'd50, 1'b0, 1'b0, 3'b000},  // R2 total 75
    {4'd5, 1'b0, 7'd0,  1'b0, 1'b0, 3'b100},  // R5 release
    {4'd8, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},  // R8 back to wait
    {4'd2, 1'b1, 7'd100,1'b0, 1'b0, 3'b000},  // R2 coin 100
    {4'd6, 1'b0, 7'd0,  1'b0, 1'b1, 3'b000},  // R6 change check
    {4'd6, 1'b0, 7'd0,  1'b0, 1'b1, 3'b010},  // R6 change pulse
    {4'd6, 1'b0, 7'd0,  1'b0, 1'b0, 3'b100},  // R6 release
    {4'd6, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd2, 1'b1, 7'd80, 1'b0, 1'b0, 3'b000},  // R2 coin 80
    {4'd7, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},  // R7 check, no change
    {4'd7, 1'b0, 7'd0,  1'b0, 1'b0, 3'b001},  // R7 refund
    {4'd7, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd3, 1'b0, 7'd0,  1'b1, 1'b0, 3'b001},  // R3 return request
    {4'd3, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd2, 1'b1, 7'd10, 1'b1, 1'b0, 3'b000},  // R2 coin beats return
    {4'd9, 1'b0, 7'd0,  1'b1, 1'b0, 3'b000},  // R9 return ignored in evaluate
    {4'd8, 1'b1, 7'd65, 1'b0, 1'b0, 3'b000},  // R8 total 75 only if cleared after refund
    {4'd9, 1'b1, 7'd127,1'b0, 1'b0, 3'b100},  // R9 coin ignored in evaluate
    {4'd9, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd8, 1'b1, 7'd74, 1'b0, 1'b0, 3'b000},  // R8 cleared after release
    {4'd4, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},  // R4 74 below price
    {4'd5, 1'b1, 7'd1,  1'b0, 1'b0, 3'b000},  // R5 74+1
    {4'd5, 1'b0, 7'd0,  1'b0, 1'b0, 3'b100},
    {4'd5, 1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd11,1'b1, 7'd74, 1'b0, 1'b0, 3'b000},  // R11 74
    {4'd11,1'b0, 7'd0,  1'b0, 1'b0, 3'b000},
    {4'd11,1'b1, 7'd127,1'b0, 1'b0, 3'b000},  // R11 201, no wrap
    {4'd11,1'b0, 7'd0,  1'b0, 1'b1, 3'b000},
    {4'd11,1'b0, 7'd0,  1'b0, 1'b1, 3'b010},
    {4'd11,1'b0, 7'd0,  1'b0, 1'b0, 3'b100},
    {4'd11,1'b0, 7'd0,  1'b0, 1'b0, 3'b000}
  };

  task automatic check(input int req, input logic [2:0] exp);
    logic [2:0] got;
    got = {release_item, give_change, refund_all};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d outputs got %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [6:0] v, input logic r, input logic c);
    @(negedge clk);
    coin_stb = s; coin_val = v; ret_req = r; chg_avail = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 3'b000);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 3'b000);  // R1 after reset
    for (int i = 0; i < NV; i++) begin
      coin_stb = VEC[i][12]; coin_val = VEC[i][11:5];
      ret_req = VEC[i][4]; chg_avail = VEC[i][3];
      @(negedge clk);
      check(int'(VEC[i][16:13]), VEC[i][2:0]);
    end
    // R1: reset in the middle of a transaction clears the total
    drive(1'b1, 7'd60, 1'b0, 1'b0);
    drive(1'b0, 7'd0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 3'b000);
    rst_n = 1'b1;
    coin_stb = 1'b1; coin_val = 7'd15;
    @(negedge clk);
    coin_stb = 1'b0;
    @(negedge clk);
    check(1, 3'b000);  // R1 15 alone stays below price
    // R3: return request from wait after the reset
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    check(3, 3'b001);
    @(negedge clk);
    check(3, 3'b000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule